// File: doc/BRIEF.md
# Event Trap Selector with Modulus Filter

This block decides, for one consumer of an event stream, whether each arriving event should be captured. It holds two trap units. Each unit compares the type and match field carried with the event's start strobe against its own configured type and match value, and can optionally invert the match sense. Events that pass this test are counted, and a modulus/remainder test on that count selects which of them are actually trapped. With several consumers each given the same modulus and a different remainder, the matching traffic is spread evenly among them.

A distribution override makes trap 0 accept every event regardless of type or match field, so only its modulus and remainder decide. In that mode trap 1 is switched off. Nothing is trapped unless the registered enable-trapping input is high. A small status word reports the enable state and one sticky hit flag per trap; a read strobe clears the flags. A trap-reset pulse zeroes both match counters.

Top module: `evtrap_sel`

## Requirements
- R1: After synchronous reset, `hit` is 0 and `status` is 0.
- R2: With distribution override off, trap i raises `hit[i]` for exactly one cycle, in the cycle after the edge that samples `ev_start`, when `ev_kind` equals `cfg_kind[i]`, `cfg_kind[i]` is not idle, the match test passes and the modulus test passes. Kind encoding: 0 = idle, 1, 2, 3 = the three event kinds.
- R3: A trap whose `cfg_kind` is 0 (idle) never hits and never counts, whatever the event kind and match field, unless it is trap 0 under distribution override.
- R4: Counting from 0 since reset or the last trap reset, the k-th event that qualifies for trap i (type, match, enable) is trapped only when k mod `cfg_mod[i]` equals `cfg_rem[i]`; the counter advances for every qualifying event whether trapped or not. The modulus must only change together with a trap reset.
- R5: A `cfg_mod[i]` of 0 behaves as a modulus of 1, so every qualifying event with remainder 0 is trapped.
- R6: With `cfg_excl[i]` = 1, the match test passes when `ev_match` differs from `cfg_match[i]` and fails when it equals it; the kind test still applies.
- R7: With `slink` = 1, every event qualifies for trap 0 regardless of kind, match field and exclusion, and trap 1 neither hits nor counts.
- R8: `trap_en_in` is registered once; `status[0]` shows the registered value, and while it is 0 no trap hits or counts.
- R9: `status[1+i]` becomes 1 in the cycle after `hit[i]` is high and stays 1 until an edge with `stat_rd` = 1 clears it; a hit present at that same edge sets it again.
- R10: `trap_reset` zeroes both match counters; an event sampled at the same edge is neither trapped nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Event start strobe, one cycle per event |
| ev_kind | input | 2 | Kind of the arriving event |
| ev_match | input | MATCH_W | Match field of the arriving event |
| trap_en_in | input | 1 | Enable-trapping level from a general-purpose input |
| slink | input | 1 | Distribution override: trap 0 takes all events, trap 1 off |
| trap_reset | input | 1 | Clears both match counters |
| stat_rd | input | 1 | Status read strobe, clears sticky hit flags |
| cfg_kind | input | 2x2 | Configured kind per trap (0 = idle) |
| cfg_match | input | 2xMATCH_W | Configured match value per trap |
| cfg_excl | input | 2 | Exclusion (inverted match) per trap |
| cfg_mod | input | 2xCNT_W | Modulus per trap (0 acts as 1) |
| cfg_rem | input | 2xCNT_W | Remainder per trap |
| hit | output | 2 | Trap hit per trap, one-cycle pulse |
| status | output | 3 | bit0 enable, bit1 sticky hit trap 0, bit2 sticky hit trap 1 |

## Verification
A trap hit is due in the cycle right after the edge that samples the event strobe, the sticky status flag one cycle after that, and the enable bit in status one cycle after the enable input changes. The bench drives every input at a falling edge and samples `hit` at the next falling edge and `status` at the one after, so each result is read exactly in the cycle it is due. A bench model holds an unbounded count of qualifying events per trap and applies the modulus as a true remainder, independent of the wrap counter in the design.

// File: rtl/evtrap_pkg.sv
package evtrap_pkg;

    localparam int NUM_TRAPS = 2;
    localparam int KIND_W    = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_IDLE = 2'd0,
        KIND_A    = 2'd1,
        KIND_B    = 2'd2,
        KIND_C    = 2'd3
    } trap_kind_e;

    // Kind test: an idle trap accepts nothing.
    function automatic logic kind_accepts(input trap_kind_e cfg, input trap_kind_e ev);
        return (cfg != KIND_IDLE) && (cfg == ev);
    endfunction

    // Match test with optional inversion.
    function automatic logic match_accepts(input logic equal, input logic invert);
        return equal ^ invert;
    endfunction

endpackage

// File: rtl/evtrap_qual.sv
module evtrap_qual
    import evtrap_pkg::*;
#(
    parameter int IDX     = 0,
    parameter int MATCH_W = 8
) (
    input  logic [KIND_W-1:0]  ev_kind,
    input  logic [MATCH_W-1:0] ev_match,
    input  logic [KIND_W-1:0]  cfg_kind,
    input  logic [MATCH_W-1:0] cfg_match,
    input  logic               cfg_excl,
    input  logic               slink,
    output logic               pass
);
    localparam bit IS_LEAD = (IDX == 0);

    logic normal_pass;

    always_comb begin
        normal_pass = kind_accepts(trap_kind_e'(cfg_kind), trap_kind_e'(ev_kind))
                    && match_accepts(ev_match == cfg_match, cfg_excl);
    end

    generate
        if (IS_LEAD) begin : g_lead
            assign pass = slink ? 1'b1 : normal_pass;
        end else begin : g_follow
            assign pass = slink ? 1'b0 : normal_pass;
        end
    endgenerate

endmodule

// File: rtl/evtrap_unit.sv
module evtrap_unit
    import evtrap_pkg::*;
#(
    parameter int IDX     = 0,
    parameter int MATCH_W = 8,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ev_start,
    input  logic [KIND_W-1:0]  ev_kind,
    input  logic [MATCH_W-1:0] ev_match,
    input  logic [KIND_W-1:0]  cfg_kind,
    input  logic [MATCH_W-1:0] cfg_match,
    input  logic               cfg_excl,
    input  logic [CNT_W-1:0]   cfg_mod,
    input  logic [CNT_W-1:0]   cfg_rem,
    input  logic               slink,
    input  logic               en,
    input  logic               clr,
    output logic               hit
);
    localparam bit IS_LEAD = (IDX == 0);

    logic             pass;
    logic             qual;
    logic [CNT_W-1:0] mod_eff;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             hit_q;

    evtrap_qual #(.IDX(IDX), .MATCH_W(MATCH_W)) u_qual (
        .ev_kind  (ev_kind),
        .ev_match (ev_match),
        .cfg_kind (cfg_kind),
        .cfg_match(cfg_match),
        .cfg_excl (cfg_excl),
        .slink    (slink),
        .pass     (pass)
    );

    always_comb begin
        mod_eff = (cfg_mod == '0) ? CNT_W'(1) : cfg_mod;
        qual    = ev_start && en && !clr && pass;
        cnt_d   = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (qual) begin
            cnt_d = (cnt_q >= mod_eff - CNT_W'(1)) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            hit_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            hit_q <= qual && (cnt_q == cfg_rem);
        end
    end

    assign hit = hit_q;

    // R2
    hit_has_event_chk: assert property (@(posedge clk) disable iff (rst)
        hit_q |-> $past(ev_start));

    // R8
    hit_has_enable_chk: assert property (@(posedge clk) disable iff (rst)
        hit_q |-> $past(en));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ev_start && cfg_kind == KIND_IDLE && !(slink && IS_LEAD)) |-> !hit_q);

    // R10
    reset_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> !hit_q);

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(qual || clr) |-> cnt_q == $past(cnt_q));

    generate
        if (!IS_LEAD) begin : g_follow_chk
            // R7
            override_quiet_chk: assert property (@(posedge clk) disable iff (rst)
                $past(slink) |-> !hit_q);
        end
    endgenerate

endmodule

// File: rtl/evtrap_status.sv
module evtrap_status #(
    parameter int NT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_in,
    input  logic [NT-1:0] hit_in,
    input  logic          rd,
    output logic          en_q,
    output logic [NT-1:0] sticky
);
    logic [NT-1:0] sticky_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            sticky_q <= '0;
        end else begin
            en_q     <= en_in;
            sticky_q <= (rd ? '0 : sticky_q) | hit_in;
        end
    end

    assign sticky = sticky_q;

    // R9
    sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
        (sticky_q & $past(hit_in)) == $past(hit_in));

    // R9
    sticky_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rd) |-> (sticky_q & $past(sticky_q)) == $past(sticky_q));

    // R8
    en_follow_chk: assert property (@(posedge clk) disable iff (rst)
        en_q == $past(en_in));

endmodule

// File: rtl/evtrap_sel.sv
module evtrap_sel
    import evtrap_pkg::*;
#(
    parameter int MATCH_W = 8,
    parameter int CNT_W   = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               ev_start,
    input  logic [KIND_W-1:0]                  ev_kind,
    input  logic [MATCH_W-1:0]                 ev_match,
    input  logic                               trap_en_in,
    input  logic                               slink,
    input  logic                               trap_reset,
    input  logic                               stat_rd,
    input  logic [NUM_TRAPS-1:0][KIND_W-1:0]   cfg_kind,
    input  logic [NUM_TRAPS-1:0][MATCH_W-1:0]  cfg_match,
    input  logic [NUM_TRAPS-1:0]               cfg_excl,
    input  logic [NUM_TRAPS-1:0][CNT_W-1:0]    cfg_mod,
    input  logic [NUM_TRAPS-1:0][CNT_W-1:0]    cfg_rem,
    output logic [NUM_TRAPS-1:0]               hit,
    output logic [NUM_TRAPS:0]                 status
);
    logic                 en_q;
    logic [NUM_TRAPS-1:0] sticky;

    generate
        for (genvar i = 0; i < NUM_TRAPS; i++) begin : g_trap
            evtrap_unit #(.IDX(i), .MATCH_W(MATCH_W), .CNT_W(CNT_W)) u_unit (
                .clk      (clk),
                .rst      (rst),
                .ev_start (ev_start),
                .ev_kind  (ev_kind),
                .ev_match (ev_match),
                .cfg_kind (cfg_kind[i]),
                .cfg_match(cfg_match[i]),
                .cfg_excl (cfg_excl[i]),
                .cfg_mod  (cfg_mod[i]),
                .cfg_rem  (cfg_rem[i]),
                .slink    (slink),
                .en       (en_q),
                .clr      (trap_reset),
                .hit      (hit[i])
            );
        end
    endgenerate

    evtrap_status #(.NT(NUM_TRAPS)) u_status (
        .clk   (clk),
        .rst   (rst),
        .en_in (trap_en_in),
        .hit_in(hit),
        .rd    (stat_rd),
        .en_q  (en_q),
        .sticky(sticky)
    );

    assign status = {sticky, en_q};

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (hit == '0 && status == '0));

endmodule

// File: tb/evtrap_sel_tb.sv
`timescale 1ns/1ps
module evtrap_sel_tb;
    import evtrap_pkg::*;

    localparam int MW = 8;
    localparam int CW = 8;
    localparam int NT = NUM_TRAPS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_start = 1'b0;
    logic [1:0] ev_kind = '0;
    logic [MW-1:0] ev_match = '0;
    logic trap_en_in = 1'b0;
    logic slink = 1'b0;
    logic trap_reset = 1'b0;
    logic stat_rd = 1'b0;
    logic [NT-1:0][1:0] cfg_kind = '0;
    logic [NT-1:0][MW-1:0] cfg_match = '0;
    logic [NT-1:0] cfg_excl = '0;
    logic [NT-1:0][CW-1:0] cfg_mod = '0;
    logic [NT-1:0][CW-1:0] cfg_rem = '0;
    logic [NT-1:0] hit;
    logic [NT:0] status;

    int checks = 0;
    int failures = 0;
    int cnt_m [NT];
    bit en_m = 1'b0;
    bit [NT-1:0] stk_m = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    evtrap_sel #(.MATCH_W(MW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .ev_start(ev_start), .ev_kind(ev_kind),
        .ev_match(ev_match), .trap_en_in(trap_en_in), .slink(slink),
        .trap_reset(trap_reset), .stat_rd(stat_rd), .cfg_kind(cfg_kind),
        .cfg_match(cfg_match), .cfg_excl(cfg_excl), .cfg_mod(cfg_mod),
        .cfg_rem(cfg_rem), .hit(hit), .status(status)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit qualifies(input int i, input logic [1:0] t, input logic [MW-1:0] m);
        if (!en_m) return 1'b0;
        if (slink) return (i == 0);
        return (cfg_kind[i] != 2'd0) && (cfg_kind[i] == t) && ((m == cfg_match[i]) != cfg_excl[i]);
    endfunction

    // One event: hit checked the next cycle, status the cycle after.
    task automatic ev(input logic [1:0] t, input logic [MW-1:0] m, input bit clr,
                      input bit rd, input string tag);
        bit [NT-1:0] exp;
        @(negedge clk);
        ev_start = 1'b1; ev_kind = t; ev_match = m; trap_reset = clr;
        exp = '0;
        for (int i = 0; i < NT; i++) begin
            int eff;
            eff = (cfg_mod[i] == 0) ? 1 : int'(cfg_mod[i]);
            if (clr) cnt_m[i] = 0;
            else if (qualifies(i, t, m)) begin
                exp[i] = ((cnt_m[i] % eff) == int'(cfg_rem[i]));
                cnt_m[i]++;
            end
        end
        @(negedge clk);
        ev_start = 1'b0; trap_reset = 1'b0;
        chk(hit == exp, {tag, " hit"}, int'(hit), int'(exp));
        stat_rd = rd;
        stk_m = rd ? exp : (stk_m | exp);
        @(negedge clk);
        stat_rd = 1'b0;
        chk(status == {stk_m, en_m}, {tag, " status"}, int'(status), int'({stk_m, en_m}));
    endtask

    task automatic do_reset_cnt();
        @(negedge clk); trap_reset = 1'b1;
        @(negedge clk); trap_reset = 1'b0;
        for (int i = 0; i < NT; i++) cnt_m[i] = 0;
    endtask

    task automatic set_en(input bit v);
        @(negedge clk); trap_en_in = v;
        @(negedge clk); en_m = v;
        chk(status[0] == v, "R8 enable bit", int'(status[0]), int'(v));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NT; i++) cnt_m[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(hit == '0, "R1 reset hit", int'(hit), 0);
        chk(status == '0, "R1 reset status", int'(status), 0);

        cfg_kind[0] = 2'd1; cfg_match[0] = 8'd5; cfg_mod[0] = 8'd1; cfg_rem[0] = 8'd0;
        cfg_kind[1] = 2'd2; cfg_match[1] = 8'd3; cfg_mod[1] = 8'd3; cfg_rem[1] = 8'd2;

        ev(2'd1, 8'd5, 0, 0, "R8 disabled");
        set_en(1'b1);
        ev(2'd1, 8'd5, 0, 0, "R2 match");
        ev(2'd1, 8'd4, 0, 0, "R2 wrong match");
        ev(2'd2, 8'd5, 0, 0, "R2 wrong kind");
        for (int k = 0; k < 6; k++) ev(2'd2, 8'd3, 0, 0, "R4 modulus three");
        ev(2'd1, 8'd5, 0, 1, "R9 read with hit");
        ev(2'd0, 8'd0, 0, 1, "R9 read clears");

        cfg_mod[0] = 8'd0; do_reset_cnt();
        for (int k = 0; k < 3; k++) ev(2'd1, 8'd5, 0, 0, "R5 modulus zero");

        cfg_kind[0] = 2'd0;
        ev(2'd0, 8'd5, 0, 0, "R3 idle kind0");
        ev(2'd1, 8'd5, 0, 0, "R3 idle kind1");

        cfg_kind[0] = 2'd1; cfg_excl[0] = 1'b1; cfg_mod[0] = 8'd1;
        ev(2'd1, 8'd5, 0, 0, "R6 excluded value");
        ev(2'd1, 8'd6, 0, 0, "R6 other value");
        ev(2'd2, 8'd6, 0, 0, "R6 kind still needed");
        cfg_excl[0] = 1'b0;

        slink = 1'b1; cfg_mod[0] = 8'd2; cfg_rem[0] = 8'd1; do_reset_cnt();
        for (int k = 0; k < 4; k++) ev(2'(k), 8'd3, 0, 0, "R7 override");
        ev(2'd2, 8'd3, 0, 0, "R7 trap1 off");
        slink = 1'b0;

        cfg_mod[0] = 8'd2; cfg_rem[0] = 8'd0;
        ev(2'd1, 8'd5, 1, 0, "R10 reset with event");
        ev(2'd1, 8'd5, 0, 0, "R10 first after reset");
        ev(2'd1, 8'd5, 0, 0, "R10 second after reset");

        set_en(1'b0);
        ev(2'd1, 8'd5, 0, 0, "R8 off again");
        set_en(1'b1);

        for (int blk = 0; blk < 40; blk++) begin
            for (int i = 0; i < NT; i++) begin
                cfg_kind[i]  = 2'($urandom_range(0, 3));
                cfg_match[i] = 8'($urandom_range(0, 3));
                cfg_excl[i]  = ($urandom_range(0, 3) == 0);
                cfg_mod[i]   = 8'($urandom_range(0, 4));
                cfg_rem[i]   = 8'($urandom_range(0, 3));
            end
            slink = ($urandom_range(0, 7) == 0);
            do_reset_cnt();
            for (int k = 0; k < 10; k++)
                ev(2'($urandom_range(0, 3)), 8'($urandom_range(0, 3)),
                   ($urandom_range(0, 15) == 0), ($urandom_range(0, 3) == 0),
                   "R2 R4 R6 R7 R9 R10 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule